// File: doc/BRIEF.md
# PCI Type-0 Configuration Address Translator

This block sits behind a CPU-side configuration window and turns each access into a type-0 PCI configuration address. A 32-bit configuration word is built from the 16-bit window offset (low half) and the low 16 bits of a configuration-map register (high half). The device select field of that word is a one-hot set of lines. Its lowest set bit gives the device number. The function and register fields are taken directly from the word, and the bus number comes from a separate input.

Each request is presented for one cycle with `req_valid_i`. Exactly one cycle later the block returns a one-cycle response. An accepted access carries the composed address with the enable bit set, together with a pulse that clears the received-master-abort and received-target-abort status bits. A rejected access carries no address. Reads that are rejected get default data of all ones at the access width. Requests flagged as type-1 in the map register are dropped quietly. Misaligned accesses and accesses with no device selected are rejected with an error flag.

Top module: `pcx_cfg_xlate`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released with no request, every output is zero.
- R2: A request sampled at a clock edge produces `rsp_valid_o` high during the following cycle only. A cycle with no request produces `rsp_valid_o` low and all other outputs zero.
- R3: When bit 16 of `map_reg_i` is set, the request is unsupported: no issue, no error and no abort-clear pulse. Reads return all ones at the access width and writes return zero data.
- R4: The configuration word is `{map_reg_i[15:0], req_offset_i}`. Its device select field is word bits [31:11], and the device number is the index of the lowest set bit in that field (0 to 20). For example, word bit 17 alone gives device 6.
- R5: The function number is word bits [10:8]. The register field is word bits [7:2], placed in address bits [7:2] with address bits [1:0] zero.
- R6: An accepted access gives `cfg_addr_o` = bit 31 set, bits [30:24] zero, bus in [23:16], device in [15:11], function in [10:8], register in [7:2].
- R7: A supported, aligned access whose device select field is all zero raises `err_o` and is not issued.
- R8: Size codes are 0 byte, 1 halfword, 2 word, 3 reserved. A halfword with offset bit 0 set, a word with offset bits [1:0] non-zero, or size code 3 raises `err_o` and is not issued. Bytes have no alignment rule.
- R9: `abort_clr_o` pulses in the response cycle of every accepted access, read or write, and in no other cycle.
- R10: `rd_default_o` is 0x000000FF, 0x0000FFFF or 0xFFFFFFFF (byte, halfword, word or reserved) for a rejected read. It is zero for writes and for accepted accesses.
- R11: The type-1 check takes priority, so a type-1 request that is also misaligned, or that has no device selected, reports no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_size_i | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_offset_i | input | 16 | Offset inside the configuration window |
| map_reg_i | input | 32 | Configuration-map register (bits [15:0] upper word, bit 16 type-1) |
| bus_num_i | input | 8 | PCI bus number |
| rsp_valid_o | output | 1 | Response cycle |
| cfg_issue_o | output | 1 | Access accepted, address valid |
| err_o | output | 1 | Misaligned access or empty device select |
| abort_clr_o | output | 1 | Pulse clearing the received-abort status bits |
| cfg_addr_o | output | 32 | Composed configuration address |
| rd_default_o | output | 32 | Default read data for rejected reads |

## Verification
Single-bit device selects at the lowest, middle and highest positions check the bit-to-number mapping at both ends of the field. Several bits set together show that the lowest one wins. A field made from both the offset and the map-register halves shows that the two sources are joined in the right order. Every size code is paired with every low-offset pattern to separate aligned from misaligned cases. Type-1 requests combined with misalignment or an empty select confirm that the type-1 check takes priority. Back-to-back and idle cycles, together with a seeded random mix of all fields, cover the one-cycle response and the abort-clear pulse on reads and writes.

// File: rtl/pcx_pkg.sv
package pcx_pkg;
    localparam int CFG_W     = 32;
    localparam int OFS_W     = 16;
    localparam int BUS_W     = 8;
    localparam int DEV_W     = 5;
    localparam int FN_W      = 3;
    localparam int SEL_LSB   = 11;
    localparam int SEL_W     = CFG_W - SEL_LSB;
    localparam int TYPE1_BIT = 16;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic             vld;
        logic             issue;
        logic             err;
        logic             clr;
        logic [CFG_W-1:0] addr;
        logic [CFG_W-1:0] rd;
    } rsp_t;

    function automatic logic [CFG_W-1:0] width_ones(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: return CFG_W'(32'h0000_00FF);
            SZ_HALF: return CFG_W'(32'h0000_FFFF);
            default: return '1;
        endcase
    endfunction
endpackage

// File: rtl/pcx_cfg_fields.sv
module pcx_cfg_fields
    import pcx_pkg::*;
(
    input  logic [OFS_W-1:0]   offset_i,
    input  logic [OFS_W-1:0]   map_lo_i,
    output logic [SEL_W-1:0]   sel_o,
    output logic [FN_W-1:0]    fn_o,
    output logic [SEL_LSB-FN_W-3:0] reg_o
);
    logic [CFG_W-1:0] word;

    assign word  = {map_lo_i, offset_i};
    assign sel_o = word[CFG_W-1:SEL_LSB];
    assign fn_o  = word[SEL_LSB-1:SEL_LSB-FN_W];
    assign reg_o = word[SEL_LSB-FN_W-1:2];
endmodule

// File: rtl/pcx_lowbit_enc.sv
module pcx_lowbit_enc #(
    parameter int W     = 21,
    parameter int IDX_W = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]     vec_i,
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o
);
    logic [W-1:0] clear_below;
    logic [W-1:0] first;

    assign clear_below[0] = 1'b1;
    genvar g;
    generate
        for (g = 1; g < W; g++) begin : g_chain
            assign clear_below[g] = clear_below[g-1] & ~vec_i[g-1];
        end
    endgenerate

    assign first   = vec_i & clear_below;
    assign found_o = |vec_i;

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < W; i++) begin
            idx_o = idx_o | (first[i] ? IDX_W'(i) : '0);
        end
    end
endmodule

// File: rtl/pcx_align_chk.sv
module pcx_align_chk
    import pcx_pkg::*;
(
    input  logic [1:0] size_i,
    input  logic [1:0] ofs_lo_i,
    output logic       ok_o
);
    always_comb begin
        case (size_i)
            SZ_BYTE: ok_o = 1'b1;
            SZ_HALF: ok_o = ~ofs_lo_i[0];
            SZ_WORD: ok_o = (ofs_lo_i == 2'b00);
            default: ok_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/pcx_cfg_xlate.sv
module pcx_cfg_xlate
    import pcx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid_i,
    input  logic             req_write_i,
    input  logic [1:0]       req_size_i,
    input  logic [OFS_W-1:0] req_offset_i,
    input  logic [CFG_W-1:0] map_reg_i,
    input  logic [BUS_W-1:0] bus_num_i,
    output logic             rsp_valid_o,
    output logic             cfg_issue_o,
    output logic             err_o,
    output logic             abort_clr_o,
    output logic [CFG_W-1:0] cfg_addr_o,
    output logic [CFG_W-1:0] rd_default_o
);
    localparam int IDX_W = $clog2(SEL_W);
    localparam int REG_W = SEL_LSB - FN_W - 2;

    logic [SEL_W-1:0] sel;
    logic [FN_W-1:0]  fn;
    logic [REG_W-1:0] regf;
    logic             sel_found;
    logic [IDX_W-1:0] sel_idx;
    logic             align_ok;
    logic             unused_map_hi;
    rsp_t             rsp_d, rsp_q;

    assign unused_map_hi = ^map_reg_i[CFG_W-1:TYPE1_BIT+1];

    pcx_cfg_fields u_fields (
        .offset_i (req_offset_i),
        .map_lo_i (map_reg_i[OFS_W-1:0]),
        .sel_o    (sel),
        .fn_o     (fn),
        .reg_o    (regf)
    );

    pcx_lowbit_enc #(.W(SEL_W), .IDX_W(IDX_W)) u_enc (
        .vec_i   (sel),
        .found_o (sel_found),
        .idx_o   (sel_idx)
    );

    pcx_align_chk u_align (
        .size_i   (req_size_i),
        .ofs_lo_i (req_offset_i[1:0]),
        .ok_o     (align_ok)
    );

    always_comb begin
        rsp_d = '0;
        if (req_valid_i) begin
            rsp_d.vld = 1'b1;
            if (map_reg_i[TYPE1_BIT]) begin
                rsp_d.rd = req_write_i ? '0 : width_ones(req_size_i);
            end else if (!align_ok || !sel_found) begin
                rsp_d.err = 1'b1;
                rsp_d.rd  = req_write_i ? '0 : width_ones(req_size_i);
            end else begin
                rsp_d.issue = 1'b1;
                rsp_d.clr   = 1'b1;
                rsp_d.addr  = {1'b1, 7'd0, bus_num_i, DEV_W'(sel_idx), fn, regf, 2'b00};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid_o  = rsp_q.vld;
    assign cfg_issue_o  = rsp_q.issue;
    assign err_o        = rsp_q.err;
    assign abort_clr_o  = rsp_q.clr;
    assign cfg_addr_o   = rsp_q.addr;
    assign rd_default_o = rsp_q.rd;
endmodule

// File: rtl/pcx_cfg_xlate_chk.sv
module pcx_cfg_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid_i,
    input logic        req_write_i,
    input logic [1:0]  req_size_i,
    input logic [15:0] req_offset_i,
    input logic [31:0] map_reg_i,
    input logic [7:0]  bus_num_i,
    input logic        rsp_valid_o,
    input logic        cfg_issue_o,
    input logic        err_o,
    input logic        abort_clr_o,
    input logic [31:0] cfg_addr_o,
    input logic [31:0] rd_default_o
);
    a_r2_follow_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |=> rsp_valid_o);
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> !rsp_valid_o && !cfg_issue_o && !err_o && !abort_clr_o);
    a_r3_type1_silent: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i && map_reg_i[16] |=> !cfg_issue_o && !err_o && !abort_clr_o);
    a_r6_enable_bit: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_issue_o |-> cfg_addr_o[31] && (cfg_addr_o[30:24] == 7'd0) && (cfg_addr_o[1:0] == 2'b00));
    a_r6_bus_field: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |=> !cfg_issue_o || (cfg_addr_o[23:16] == $past(bus_num_i)));
    a_r7_err_no_issue: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !cfg_issue_o && (cfg_addr_o == 32'd0));
    a_r8_word_misalign: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i && !map_reg_i[16] && (req_size_i == 2'd2) && (req_offset_i[1:0] != 2'b00) |=> err_o);
    a_r9_clr_only_issue: assert property (@(posedge clk) disable iff (!rst_n)
        abort_clr_o |-> cfg_issue_o && rsp_valid_o);
    a_r10_write_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i && req_write_i |=> rd_default_o == 32'd0);
endmodule

bind pcx_cfg_xlate pcx_cfg_xlate_chk u_chk (.*);

// File: tb/pcx_cfg_xlate_bench.sv
`timescale 1ns/1ps
module pcx_cfg_xlate_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid_i = 1'b0;
    logic        req_write_i = 1'b0;
    logic [1:0]  req_size_i = 2'd0;
    logic [15:0] req_offset_i = '0;
    logic [31:0] map_reg_i = '0;
    logic [7:0]  bus_num_i = '0;
    logic        rsp_valid_o, cfg_issue_o, err_o, abort_clr_o;
    logic [31:0] cfg_addr_o, rd_default_o;

    int n_vec = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    pcx_cfg_xlate u_pcx_cfg_xlate (.*);

    function automatic logic [67:0] model(input logic w, input logic [1:0] sz,
                                          input logic [15:0] off, input logic [31:0] map,
                                          input logic [7:0] bus);
        logic [31:0] word, ones, addr, rd;
        logic        iss, er, clr, found;
        int          dev;
        word = {map[15:0], off};
        ones = (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
        iss = 0; er = 0; clr = 0; addr = 0; rd = 0; found = 0; dev = 0;
        if (map[16]) begin
            rd = w ? 32'd0 : ones;
        end else if ((sz == 2'd3) || (sz == 2'd1 && off[0]) || (sz == 2'd2 && off[1:0] != 2'b00)) begin
            er = 1; rd = w ? 32'd0 : ones;
        end else begin
            for (int i = 0; i < 21; i++) begin
                if (!found && word[11+i]) begin found = 1; dev = i; end
            end
            if (!found) begin
                er = 1; rd = w ? 32'd0 : ones;
            end else begin
                iss = 1; clr = 1;
                addr = 32'h8000_0000 | (32'(bus) << 16) | (32'(dev) << 11)
                     | (32'(word[10:8]) << 8) | (32'(word[7:0]) & 32'hFC);
            end
        end
        return {1'b1, iss, er, clr, addr, rd};
    endfunction

    function automatic logic [67:0] observed();
        return {rsp_valid_o, cfg_issue_o, err_o, abort_clr_o, cfg_addr_o, rd_default_o};
    endfunction

    task automatic check(input string tag, input logic [67:0] got, input logic [67:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic send(input string tag, input logic w, input logic [1:0] sz,
                        input logic [15:0] off, input logic [31:0] map, input logic [7:0] bus);
        logic [67:0] exp;
        req_valid_i = 1; req_write_i = w; req_size_i = sz;
        req_offset_i = off; map_reg_i = map; bus_num_i = bus;
        exp = model(w, sz, off, map, bus);
        @(negedge clk);
        check(tag, observed(), exp);
    endtask

    task automatic idle(input string tag);
        req_valid_i = 0;
        req_offset_i = 16'hFFFF; map_reg_i = 32'h0000_FFFF;
        @(negedge clk);
        check(tag, observed(), 68'd0);
    endtask

    initial begin
        #(20.0 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        check("R1 in reset", observed(), 68'd0);
        rst_n = 1;
        @(negedge clk);
        check("R1 after release", observed(), 68'd0);

        // R4: word bit 17 -> device 6, address 0x80003000
        send("R4 bit17 dev6", 0, 2'd2, 16'h0000, 32'h0000_0002, 8'h00);
        check("R4 literal addr", {32'(cfg_addr_o)}, {32'h8000_3000});
        // R5 R6: lowest select bit from offset, function 5, register 0x3C
        send("R5 R6 fields", 0, 2'd2, 16'h0D3C, 32'h0, 8'h12);
        check("R6 literal addr", {32'(cfg_addr_o)}, {32'h8012_053C});
        send("R4 several set lowest wins", 0, 2'd0, 16'h0000, 32'h0000_0F00, 8'hA5);
        send("R4 highest select bit", 1, 2'd1, 16'h0002, 32'h0000_8000, 8'hFF);
        send("R5 byte unaligned reg low bits", 0, 2'd0, 16'h0803, 32'h0, 8'h01);
        send("R7 empty select read", 0, 2'd1, 16'h07FC, 32'h0, 8'h00);
        send("R7 empty select write", 1, 2'd2, 16'h0000, 32'h0, 8'h00);
        send("R3 type1 byte read", 0, 2'd0, 16'h0800, 32'h0001_0002, 8'h00);
        send("R3 type1 word write", 1, 2'd2, 16'h0800, 32'h0001_0002, 8'h00);
        send("R11 type1 misaligned", 0, 2'd2, 16'h0802, 32'h0001_0000, 8'h00);
        send("R11 type1 empty select", 0, 2'd1, 16'h0000, 32'h0001_0000, 8'h00);
        send("R8 half misaligned", 0, 2'd1, 16'h0801, 32'h0, 8'h00);
        send("R8 word misaligned", 0, 2'd2, 16'h0802, 32'h0, 8'h00);
        send("R8 reserved size", 0, 2'd3, 16'h0800, 32'h0, 8'h00);
        send("R10 reserved size write", 1, 2'd3, 16'h0800, 32'h0, 8'h00);
        send("R9 accepted write", 1, 2'd2, 16'h1004, 32'h0, 8'h03);
        idle("R2 idle after write");
        idle("R9 no pulse idle");
        send("R2 single after idle", 0, 2'd2, 16'h4000, 32'h0, 8'h07);
        idle("R2 response one cycle");

        for (int k = 0; k < 400; k++) begin
            logic [31:0] m;
            logic [15:0] o;
            m = $urandom;
            o = 16'($urandom);
            if (($urandom % 8) != 0) m[16] = 1'b0;
            if (($urandom % 6) == 0) begin m[15:0] = '0; o[15:11] = '0; end
            send("R3 R4 R5 R6 R7 R8 R9 R10 random", 1'($urandom), 2'($urandom), o, m, 8'($urandom));
            if (($urandom % 10) == 0) idle("R2 random idle");
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule